// File: doc/BRIEF.md
# Configuration Image Payload Locator

This block sits between a byte source that delivers a configuration image and the logic that consumes the image's payload. It takes the image one byte at a time over a valid/ready handshake. It throws away everything ahead of the payload and passes only payload bytes downstream, over a second valid/ready handshake. A start pulse begins each image. The image length and the search mode are sampled together with that pulse.

There are two search modes.

- **Raw mode.** The block first walks a chain of four length-prefixed text fields in the image header. It then looks for a run of four 0xFF bytes. That run is the first part of the payload and is passed on. Because the search consumes the run before the match is known, the block replays the four fill bytes itself before it resumes pass-through.
- **Compressed mode.** No header walk is done. The search starts at byte zero and looks for a two-byte sync marker. The marker is dropped, and the payload begins right after it.

When the payload begins, the block pulses a flag and records the payload's byte offset. If the image ends without a match, it raises a sticky flag instead.

Top module: `cfg_image_locator`

## Requirements
- R1: While reset is applied, and after reset until a start, `in_ready`, `out_valid`, `payload_start` and `not_found` are all low.
- R2: In raw mode (`mode_i`=0), the first field length byte sits at byte offset 15. A field whose length byte L sits at offset p is followed by the next field at offset p+L+3. After the fourth field, the search begins at the offset that field points to. Header bytes, even 0xFF ones, are never searched or forwarded, and a chain that runs past the image end gives not-found.
- R3: In raw mode, the payload begins at the first byte of the earliest run of four consecutive 0xFF bytes at or after the search base. All four of those bytes are forwarded.
- R4: In compressed mode (`mode_i`=1), the search starts at offset 0 for a 0xFF byte directly followed by a byte whose bits 7:4 equal 4'h3. Both marker bytes are dropped, and the payload begins two bytes after the 0xFF.
- R5: The forwarded stream equals the image bytes from the payload offset up to the last image byte (offset size-1), in order, whatever the output stalls. A marker that ends the image gives an empty payload.
- R6: `payload_start` is a one-cycle pulse in the cycle after the byte that completes the match is accepted. From that cycle, `payload_offset` holds the payload's byte offset and changes only with that pulse.
- R7: If the last image byte is accepted with no match, `not_found` rises the next cycle. It stays high until the next start. No `payload_start` and no output follow.
- R8: `mode_i` and `img_size_i` are sampled only on a `start_i` taken while idle. Changing them later has no effect on the current image.
- R9: While the held 0xFF bytes are replayed in raw mode, `in_ready` is low. A stalled output keeps `out_valid` high and `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new image (taken while idle) |
| mode_i | input | 1 | 0 = raw search, 1 = compressed search |
| img_size_i | input | SZW | Image length in bytes (at least 2) |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte valid |
| in_ready | output | 1 | Block accepts the image byte |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream accepts the payload byte |
| payload_start | output | 1 | One-cycle pulse when the payload begins |
| payload_offset | output | SZW | Byte offset of the first payload byte |
| not_found | output | 1 | Image ended without a preamble match |

## Verification
The hardest case to reach from the ports is a raw preamble that completes on the very last image byte while the output is stalled. Here the block must replay the held fill bytes with its input closed, and then return to idle rather than to pass-through. The bench reaches this case with an image that ends exactly at the preamble, fed while `out_ready` is forced low. It probes the ports in the stalled state, then releases the output and counts the replayed bytes. The table also places runs of three 0xFF bytes just ahead of the preamble, and fills the header with 0xFF, so that a partial run or header content would move the offset if either one were mishandled.

// File: rtl/cil_pkg.sv
package cil_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_SCAN = 3'd2,
    ST_HOLD = 3'd3,
    ST_FWD  = 3'd4
  } cil_state_e;

  localparam int unsigned HDR_FIRST  = 15;
  localparam int unsigned HDR_FIELDS = 4;
  localparam int unsigned HDR_GAP    = 3;
  localparam int unsigned RAW_RUN    = 4;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [3:0] SYNC_HI   = 4'h3;

  // offset of the next header field given the current length byte
  function automatic logic [31:0] next_field(input logic [31:0] pos, input logic [7:0] len);
    return pos + 32'(len) + 32'(HDR_GAP);
  endfunction

  // second byte of the compressed-mode marker
  function automatic logic is_sync_tail(input logic [7:0] b);
    return b[7:4] == SYNC_HI;
  endfunction

  // first payload offset given the offset of the byte completing the match
  function automatic logic [31:0] first_payload(input logic cmp, input logic [31:0] at);
    return cmp ? at + 32'd1 : at - 32'(RAW_RUN - 1);
  endfunction

endpackage

// File: rtl/cil_hdr_walk.sv
module cil_hdr_walk
  import cil_pkg::*;
#(
  parameter int SZW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           step_i,
  input  logic [SZW-1:0] idx_i,
  input  logic [7:0]     byte_i,
  output logic           field_hit_o,
  output logic           done_o,
  output logic           at_base_o
);

  localparam int CW = $clog2(HDR_FIELDS + 1);

  logic [31:0]   next_q;
  logic [CW-1:0] left_q;
  logic [31:0]   idx_w;

  assign idx_w       = 32'(idx_i);
  assign done_o      = (left_q == '0);
  assign field_hit_o = !done_o && (idx_w == next_q);
  assign at_base_o   = done_o && (idx_w == next_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= 32'(HDR_FIRST);
      left_q <= CW'(HDR_FIELDS);
    end else if (clear_i) begin
      next_q <= 32'(HDR_FIRST);
      left_q <= CW'(HDR_FIELDS);
    end else if (step_i && field_hit_o) begin
      next_q <= next_field(next_q, byte_i);
      left_q <= left_q - CW'(1);
    end
  end

endmodule

// File: rtl/cil_sync_match.sv
module cil_sync_match
  import cil_pkg::*;
#(
  parameter int SZW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           cmp_i,
  input  logic           step_i,
  input  logic [7:0]     byte_i,
  input  logic [SZW-1:0] idx_i,
  output logic           hit_o,
  output logic [SZW-1:0] hit_ofs_o
);

  localparam int RW = $clog2(RAW_RUN);

  logic [RW-1:0] run_q;
  logic          prev_ff_q;
  logic          is_ff;
  logic          run_hit;
  logic          sync_hit;

  assign is_ff     = (byte_i == FILL_BYTE);
  assign run_hit   = is_ff && (run_q == RW'(RAW_RUN - 1));
  assign sync_hit  = prev_ff_q && is_sync_tail(byte_i);
  assign hit_o     = step_i && (cmp_i ? sync_hit : run_hit);
  assign hit_ofs_o = SZW'(first_payload(cmp_i, 32'(idx_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      prev_ff_q <= 1'b0;
    end else if (clear_i) begin
      run_q     <= '0;
      prev_ff_q <= 1'b0;
    end else if (step_i) begin
      prev_ff_q <= is_ff;
      if (!is_ff)       run_q <= '0;
      else if (!run_hit) run_q <= run_q + RW'(1);
    end
  end

endmodule

// File: rtl/cil_emit.sv
module cil_emit
  import cil_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       hold_i,
  input  logic       fwd_i,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       out_ready_i,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  output logic       drained_o
);

  localparam int PW = $clog2(RAW_RUN + 1);

  logic [PW-1:0] pend_q;

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = 8'h00;
    if (hold_i) begin
      out_valid_o = 1'b1;
      out_data_o  = FILL_BYTE;
    end else if (fwd_i) begin
      out_valid_o = in_valid_i;
      out_data_o  = in_data_i;
    end
  end

  assign drained_o = hold_i && out_ready_i && (pend_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pend_q <= '0;
    else if (load_i)                              pend_q <= PW'(RAW_RUN);
    else if (hold_i && out_ready_i && pend_q != '0) pend_q <= pend_q - PW'(1);
  end

endmodule

// File: rtl/cfg_image_locator.sv
module cfg_image_locator
  import cil_pkg::*;
#(
  parameter int SZW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic [SZW-1:0] img_size_i,
  input  logic [7:0]     in_data,
  input  logic           in_valid,
  output logic           in_ready,
  output logic [7:0]     out_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           payload_start,
  output logic [SZW-1:0] payload_offset,
  output logic           not_found
);

  cil_state_e     st_q, st_d;
  logic           cmp_q;
  logic [SZW-1:0] size_q;
  logic [SZW-1:0] idx_q;
  logic           ps_q;
  logic [SZW-1:0] ofs_q;
  logic           nf_q;
  logic           tail_q;

  // named events (also observed by the checker)
  logic           launch;
  logic           acc;
  logic           last_byte;
  logic           hdr_step;
  logic           scan_step;
  logic           hit_ev;
  logic           end_miss_ev;
  logic           hold_act;
  logic           fwd_act;
  logic           drained;
  logic           field_hit;
  logic           hdr_done;
  logic           at_base;
  logic [SZW-1:0] hit_ofs;

  assign launch    = (st_q == ST_IDLE) && start_i;
  assign hold_act  = (st_q == ST_HOLD);
  assign fwd_act   = (st_q == ST_FWD);
  assign in_ready  = ((st_q == ST_HDR) && !at_base) || (st_q == ST_SCAN) || (fwd_act && out_ready);
  assign acc       = in_valid && in_ready;
  assign last_byte = (idx_q == size_q - SZW'(1));
  assign hdr_step  = acc && (st_q == ST_HDR);
  assign scan_step = acc && (st_q == ST_SCAN);
  assign end_miss_ev = (hdr_step || scan_step) && last_byte && !hit_ev;

  cil_hdr_walk #(.SZW(SZW)) hdr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (launch),
    .step_i     (hdr_step),
    .idx_i      (idx_q),
    .byte_i     (in_data),
    .field_hit_o(field_hit),
    .done_o     (hdr_done),
    .at_base_o  (at_base)
  );

  cil_sync_match #(.SZW(SZW)) match_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (launch),
    .cmp_i    (cmp_q),
    .step_i   (scan_step),
    .byte_i   (in_data),
    .idx_i    (idx_q),
    .hit_o    (hit_ev),
    .hit_ofs_o(hit_ofs)
  );

  cil_emit emit_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (hit_ev && !cmp_q),
    .hold_i     (hold_act),
    .fwd_i      (fwd_act),
    .in_data_i  (in_data),
    .in_valid_i (in_valid),
    .out_ready_i(out_ready),
    .out_data_o (out_data),
    .out_valid_o(out_valid),
    .drained_o  (drained)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch) st_d = mode_i ? ST_SCAN : ST_HDR;
      ST_HDR: begin
        if (end_miss_ev)                 st_d = ST_IDLE;
        else if (at_base && hdr_done)    st_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (hit_ev) begin
          if (!cmp_q)         st_d = ST_HOLD;
          else if (last_byte) st_d = ST_IDLE;
          else                st_d = ST_FWD;
        end else if (end_miss_ev) begin
          st_d = ST_IDLE;
        end
      end
      ST_HOLD: if (drained) st_d = tail_q ? ST_IDLE : ST_FWD;
      ST_FWD:  if (acc && last_byte) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmp_q  <= 1'b0;
      size_q <= '0;
      idx_q  <= '0;
      ps_q   <= 1'b0;
      ofs_q  <= '0;
      nf_q   <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ps_q <= hit_ev;
      if (launch) begin
        cmp_q  <= mode_i;
        size_q <= img_size_i;
        idx_q  <= '0;
        nf_q   <= 1'b0;
      end else if (acc) begin
        idx_q <= idx_q + SZW'(1);
      end
      if (end_miss_ev) nf_q <= 1'b1;
      if (hit_ev) begin
        ofs_q  <= hit_ofs;
        tail_q <= last_byte;
      end
    end
  end

  assign payload_start  = ps_q;
  assign payload_offset = ofs_q;
  assign not_found      = nf_q;

endmodule

// File: rtl/cil_chk.sv
module cil_chk #(
  parameter int SZW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_data,
  input logic           payload_start,
  input logic [SZW-1:0] payload_offset,
  input logic           not_found,
  input logic           hold_act,
  input logic           hit_ev
);

  // R6: the start flag lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    payload_start |=> !payload_start);

  // R6: a completed match is announced on the next cycle
  p_hit_announce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (payload_start && !not_found));

  // R6: the offset moves only together with the start flag
  p_ofs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(payload_offset) |-> payload_start);

  // R7: not-found persists until a new start
  p_nf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (not_found && !start_i) |=> not_found);

  // R7: nothing is emitted for an unmatched image
  p_nf_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> (!out_valid && !payload_start));

  // R9: the input is closed while fill bytes are replayed
  p_drain_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> (!in_ready && out_valid));

  // R9: a stalled replay keeps its byte
  p_drain_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind cfg_image_locator cil_chk #(.SZW(SZW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .payload_start (payload_start),
  .payload_offset(payload_offset),
  .not_found     (not_found),
  .hold_act      (hold_act),
  .hit_ev        (hit_ev)
);

// File: tb/cfg_image_locator_tb_top.sv
module cfg_image_locator_tb_top;

  localparam int SZW = 16;

  typedef struct packed {
    logic        cmp;
    logic [7:0]  l0, l1, l2, l3;
    logic [7:0]  junk;
    logic [7:0]  pay;
    logic        pre;
    logic [15:0] ofs;
    logic        nf;
  } vec_t;

  localparam int NCASE = 9;
  localparam vec_t CASES [NCASE] = '{
    '{1'b0, 8'd2, 8'd0, 8'd5, 8'd1, 8'd0,  8'd6, 1'b1, 16'd35, 1'b0},
    '{1'b0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd6,  8'd5, 1'b1, 16'd35, 1'b0},
    '{1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd8,  8'd0, 1'b1, 16'd35, 1'b0},
    '{1'b0, 8'd3, 8'd2, 8'd1, 8'd0, 8'd7,  8'd3, 1'b1, 16'd37, 1'b0},
    '{1'b0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd9,  8'd4, 1'b0, 16'd0,  1'b1},
    '{1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd5, 1'b1, 16'd2,  1'b0},
    '{1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd7,  8'd4, 1'b1, 16'd9,  1'b0},
    '{1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd5,  8'd0, 1'b1, 16'd7,  1'b0},
    '{1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd10, 8'd3, 1'b0, 16'd0,  1'b1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic           mode_i = 1'b0;
  logic [SZW-1:0] img_size_i = '0;
  logic [7:0]     in_data = 8'h00;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [7:0]     out_data;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic           payload_start;
  logic [SZW-1:0] payload_offset;
  logic           not_found;

  always #4 clk = ~clk;

  cfg_image_locator #(.SZW(SZW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .img_size_i(img_size_i), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .payload_start(payload_start),
    .payload_offset(payload_offset), .not_found(not_found)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] img [0:255];
  int         img_len = 0;
  logic [7:0] obuf [0:255];
  int         out_cnt = 0;
  int         ps_cnt = 0;
  logic [15:0] lf = 16'hACE1;
  bit         ready_off = 1'b0;
  int         cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // downstream ready pattern, changed after each edge
  always begin
    @(posedge clk);
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready = ready_off ? 1'b0 : (lf[0] | lf[3]);
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        obuf[out_cnt] = out_data;
        out_cnt = out_cnt + 1;
      end
      if (payload_start) ps_cnt = ps_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic build(input vec_t v);
    int p;
    logic [7:0] lens [4];
    p = 0;
    lens[0] = v.l0; lens[1] = v.l1; lens[2] = v.l2; lens[3] = v.l3;
    if (!v.cmp) begin
      for (int i = 0; i < 15; i++) begin img[p] = 8'hFF; p++; end
      for (int f = 0; f < 4; f++) begin
        img[p] = lens[f]; p++;
        for (int k = 0; k < int'(lens[f]) + 2; k++) begin img[p] = 8'hFF; p++; end
      end
    end
    for (int i = 0; i < int'(v.junk); i++) begin
      if (!v.cmp) img[p] = (i % 4 == 3) ? 8'h00 : 8'hFF;
      else        img[p] = (i % 3 == 0) ? 8'hFF : ((i % 3 == 1) ? 8'h2C : 8'h35);
      p++;
    end
    if (v.pre) begin
      if (!v.cmp) for (int i = 0; i < 4; i++) begin img[p] = 8'hFF; p++; end
      else begin img[p] = 8'hFF; img[p+1] = 8'h3A; p += 2; end
    end
    for (int i = 0; i < int'(v.pay); i++) begin
      img[p] = v.cmp ? 8'(8'h40 + i) : 8'(8'h30 + i);
      p++;
    end
    img_len = p;
  endtask

  task automatic feed(input logic cmp);
    bit got;
    out_cnt = 0;
    ps_cnt = 0;
    @(posedge clk); #1;
    mode_i = cmp; img_size_i = SZW'(img_len); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    mode_i = ~cmp; img_size_i = '1;   // R8: late changes must not matter
    for (int k = 0; k < img_len; k++) begin
      if (lf[5] & lf[7]) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_data = img[k];
      in_valid = 1'b1;
      do begin
        @(negedge clk);
        got = in_ready;
        @(posedge clk); #1;
      end while (!got);
    end
    in_valid = 1'b0;
  endtask

  task automatic judge(input logic cmp, input int eofs, input logic enf);
    int exp_n;
    int bad;
    string rq;
    rq = cmp ? "R4" : "R3";
    chk(not_found == enf, "R7 not_found", int'(not_found), int'(enf));
    chk(ps_cnt == (enf ? 0 : 1), "R6 payload_start pulses", ps_cnt, enf ? 0 : 1);
    if (!enf) chk(int'(payload_offset) == eofs, {rq, " R2 payload_offset"}, int'(payload_offset), eofs);
    exp_n = enf ? 0 : img_len - eofs;
    chk(out_cnt == exp_n, "R5 R8 forwarded count", out_cnt, exp_n);
    bad = 0;
    for (int i = 0; i < out_cnt && i < exp_n; i++)
      if (obuf[i] !== img[eofs + i]) bad++;
    chk(bad == 0, "R5 forwarded bytes", bad, 0);
    if (!enf && !cmp) begin
      bad = 0;
      for (int i = 0; i < 4 && i < out_cnt; i++) if (obuf[i] !== 8'hFF) bad++;
      chk(bad == 0 && out_cnt >= 4, "R3 preamble forwarded", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!in_ready && !out_valid, "R1 handshake idle in reset", int'(in_ready) + int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !out_valid && !payload_start && !not_found, "R1 idle after reset",
        int'(in_ready) + int'(out_valid) + int'(payload_start) + int'(not_found), 0);

    // table-driven images
    for (int c = 0; c < NCASE; c++) begin
      build(CASES[c]);
      feed(CASES[c].cmp);
      repeat (30) @(posedge clk);
      @(negedge clk);
      judge(CASES[c].cmp, int'(CASES[c].ofs), CASES[c].nf);
    end

    // R2: header chain runs off the image; its 0xFF content must not match
    for (int i = 0; i < 30; i++) img[i] = 8'hFF;
    img[15] = 8'd200;
    img_len = 30;
    feed(1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(not_found == 1'b1, "R2 header overrun gives not_found", int'(not_found), 1);
    chk(out_cnt == 0 && ps_cnt == 0, "R2 header bytes never forwarded", out_cnt + ps_cnt, 0);

    // R9: preamble ends the image while the output is stalled
    ready_off = 1'b1;
    build(CASES[2]);
    feed(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid && out_data == 8'hFF, "R9 replay byte held", int'(out_data), 255);
    chk(!in_ready, "R9 input closed during replay", int'(in_ready), 0);
    ready_off = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(out_cnt == 4, "R9 four fill bytes replayed", out_cnt, 4);
    chk(!out_valid && !in_ready, "R5 idle after tail preamble", int'(out_valid) + int'(in_ready), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule